// File: doc/BRIEF.md
# BCD Alarm Setting and Match Unit

This unit sits beside a running time-of-day clock. It stores an alarm time as a packed-BCD hour and minute and lights an alarm indicator while the current time equals that stored time. The alarm time is set by hand. The main clock is first stopped and alarm-set mode is switched on. Then, on every 1 Hz tick, the hour adjust switch steps the alarm hour and the minute adjust switch steps the alarm minute.

The indicator depends only on the present level of its inputs and is registered in the system clock domain. It lights one clock after the match condition becomes true. It stays lit for the whole matching minute. It goes dark one clock after the minute moves on or the alarm is disabled.

The unit also drives a select line that tells a downstream display whether to show the alarm time or the current time. The current hour is always taken as a 24-hour BCD value.

Top module: `alarm_unit`

## Requirements
- R1: The alarm minute is packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. It only holds values 00 to 59, and a step from 59 gives 00.
- R2: The alarm minute advances by one on a clock edge only when all four of these hold: `tick_i` is high, `run_i` is low, `set_mode_i` is high and `adj_min_i` is high. Otherwise it keeps its value, even if `tick_i` pulses.
- R3: The alarm hour is packed BCD with the same digit layout as the minute. It only holds values 00 to 23, and a step from 23 gives 00.
- R4: The alarm hour advances by one on a clock edge only when all four of these hold: `tick_i` is high, `run_i` is low, `set_mode_i` is high and `adj_hr_i` is high. Stepping the hour never changes the minute.
- R5: `led_o` is high one clock after all of these are true: `run_i` is high, `alarm_en_i` is high, `cur_hr_i` equals the alarm hour and `cur_min_i` equals the alarm minute. It stays high for as long as they remain true.
- R6: `led_o` falls one clock after the current hour or minute stops matching the alarm time.
- R7: `led_o` falls one clock after `alarm_en_i` goes low, even while the time still matches.
- R8: `led_o` stays low while `run_i` is low, even if the current time matches the alarm time.
- R9: `show_alarm_o` is high when `set_mode_i` is high and low otherwise. High selects the alarm time for display.
- R10: A low `clr_n_i` sets the alarm hour and minute to 00 and `led_o` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| clr_n_i | input | 1 | Asynchronous clear, active low |
| tick_i | input | 1 | One-cycle 1 Hz step pulse |
| run_i | input | 1 | Main clock is counting |
| set_mode_i | input | 1 | Alarm-set mode switch |
| adj_min_i | input | 1 | Minute adjust switch |
| adj_hr_i | input | 1 | Hour adjust switch |
| alarm_en_i | input | 1 | Alarm enable switch |
| cur_hr_i | input | 8 | Current hour, 24-hour packed BCD |
| cur_min_i | input | 8 | Current minute, packed BCD |
| alm_hr_o | output | 8 | Stored alarm hour, packed BCD |
| alm_min_o | output | 8 | Stored alarm minute, packed BCD |
| show_alarm_o | output | 1 | Display select: 1 shows the alarm time |
| led_o | output | 1 | Alarm indicator |

## Verification
The stored alarm digits are visible directly on `alm_hr_o` and `alm_min_o`. A wrong step, a missing rollover or a corrupted digit therefore appears at the ports on the very clock edge that causes it, and the per-cycle reference comparison catches it there. Errors in the match path, such as a wrong compare or a missing enable term, show up at `led_o` exactly one clock after the inputs that should have lit or cleared it. A clear that fails to act asynchronously is caught by sampling the outputs in the middle of a cycle, before any clock edge arrives.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int DIGIT_W = 4;
    localparam int PAIR_W  = 2 * DIGIT_W;
    localparam int FIELDS  = 2;

    typedef struct packed {
        logic [DIGIT_W-1:0] tens;
        logic [DIGIT_W-1:0] units;
    } bcd2_t;

    localparam bcd2_t MINUTE_MAX = '{tens: 4'd5, units: 4'd9};
    localparam bcd2_t HOUR_MAX   = '{tens: 4'd2, units: 4'd3};
    localparam bcd2_t BCD_ZERO   = '{tens: '0, units: '0};
endpackage

// File: rtl/bcd_wrap_counter.sv
module bcd_wrap_counter
    import alarm_pkg::*;
#(
    parameter bcd2_t LIMIT = MINUTE_MAX
) (
    input  logic  clk_i,
    input  logic  clr_n_i,
    input  logic  step_i,
    output bcd2_t val_o
);
    typedef struct packed {
        bcd2_t val;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       legal;

    always_comb begin
        legal = (st_q.val.units <= DIGIT_W'(9)) && (st_q.val.tens <= DIGIT_W'(9))
                && (st_q.val <= LIMIT);
        st_d = st_q;
        if (step_i) begin
            if (!legal || st_q.val == LIMIT) begin
                st_d.val = BCD_ZERO;
            end else if (st_q.val.units == DIGIT_W'(9)) begin
                st_d.val.units = '0;
                st_d.val.tens  = st_q.val.tens + DIGIT_W'(1);
            end else begin
                st_d.val.units = st_q.val.units + DIGIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge clr_n_i) begin
        if (!clr_n_i) begin
            st_q <= '{val: BCD_ZERO};
        end else begin
            st_q <= st_d;
        end
    end

    assign val_o = st_q.val;
endmodule

// File: rtl/alarm_hit_reg.sv
module alarm_hit_reg
    import alarm_pkg::*;
(
    input  logic  clk_i,
    input  logic  clr_n_i,
    input  logic  armed_i,
    input  bcd2_t cur_hr_i,
    input  bcd2_t cur_min_i,
    input  bcd2_t alm_hr_i,
    input  bcd2_t alm_min_i,
    output logic  led_o
);
    typedef struct packed {
        logic led;
    } hit_state_t;

    hit_state_t st_d, st_q;
    logic [FIELDS-1:0] same;

    always_comb begin
        same[0] = (cur_min_i == alm_min_i);
        same[1] = (cur_hr_i == alm_hr_i);
        st_d.led = armed_i && (&same);
    end

    always_ff @(posedge clk_i or negedge clr_n_i) begin
        if (!clr_n_i) begin
            st_q <= '{led: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign led_o = st_q.led;
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
    import alarm_pkg::*;
(
    input  logic              clk_i,
    input  logic              clr_n_i,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              set_mode_i,
    input  logic              adj_min_i,
    input  logic              adj_hr_i,
    input  logic              alarm_en_i,
    input  logic [PAIR_W-1:0] cur_hr_i,
    input  logic [PAIR_W-1:0] cur_min_i,
    output logic [PAIR_W-1:0] alm_hr_o,
    output logic [PAIR_W-1:0] alm_min_o,
    output logic              show_alarm_o,
    output logic              led_o
);
    logic              adjust_ok;
    logic [FIELDS-1:0] step;
    bcd2_t             field_val [FIELDS];

    assign adjust_ok = tick_i & ~run_i & set_mode_i;
    assign step[0]   = adjust_ok & adj_min_i;
    assign step[1]   = adjust_ok & adj_hr_i;

    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        bcd_wrap_counter #(
            .LIMIT((g == 0) ? MINUTE_MAX : HOUR_MAX)
        ) u_cnt (
            .clk_i   (clk_i),
            .clr_n_i (clr_n_i),
            .step_i  (step[g]),
            .val_o   (field_val[g])
        );
    end

    alarm_hit_reg u_hit (
        .clk_i     (clk_i),
        .clr_n_i   (clr_n_i),
        .armed_i   (run_i & alarm_en_i),
        .cur_hr_i  (bcd2_t'(cur_hr_i)),
        .cur_min_i (bcd2_t'(cur_min_i)),
        .alm_hr_i  (field_val[1]),
        .alm_min_i (field_val[0]),
        .led_o     (led_o)
    );

    assign alm_min_o    = field_val[0];
    assign alm_hr_o     = field_val[1];
    assign show_alarm_o = set_mode_i;
endmodule

// File: rtl/alarm_unit_chk.sv
module alarm_unit_chk (
    input logic       clk_i,
    input logic       clr_n_i,
    input logic       tick_i,
    input logic       run_i,
    input logic       set_mode_i,
    input logic       adj_min_i,
    input logic       adj_hr_i,
    input logic       alarm_en_i,
    input logic [7:0] cur_hr_i,
    input logic [7:0] cur_min_i,
    input logic [7:0] alm_hr_o,
    input logic [7:0] alm_min_o,
    input logic       led_o
);
    a_r1_min_legal: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        (alm_min_o[3:0] <= 4'd9) && (alm_min_o <= 8'h59));

    a_r3_hr_legal: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        (alm_hr_o[3:0] <= 4'd9) && (alm_hr_o <= 8'h23));

    a_r2_min_hold: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        !(tick_i && !run_i && set_mode_i && adj_min_i) |=> $stable(alm_min_o));

    a_r4_hr_hold: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        !(tick_i && !run_i && set_mode_i && adj_hr_i) |=> $stable(alm_hr_o));

    a_r1_min_wrap: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        (tick_i && !run_i && set_mode_i && adj_min_i && alm_min_o == 8'h59)
        |=> (alm_min_o == 8'h00));

    a_r3_hr_wrap: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        (tick_i && !run_i && set_mode_i && adj_hr_i && alm_hr_o == 8'h23)
        |=> (alm_hr_o == 8'h00));

    a_r5_led_on: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        (run_i && alarm_en_i && cur_hr_i == alm_hr_o && cur_min_i == alm_min_o)
        |=> led_o);

    a_r6_led_off: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        !(run_i && alarm_en_i && cur_hr_i == alm_hr_o && cur_min_i == alm_min_o)
        |=> !led_o);
endmodule

bind alarm_unit alarm_unit_chk u_chk (.*);

// File: tb/tb_alarm_unit.sv
module tb_alarm_unit;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       tick = 1'b0, run = 1'b0, set_mode = 1'b0;
    logic       adj_min = 1'b0, adj_hr = 1'b0, en = 1'b0;
    logic [7:0] cur_hr = 8'h00, cur_min = 8'h00;
    logic [7:0] alm_hr, alm_min;
    logic       show, led;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int   m_min = 0, m_hr = 0;
    logic m_led = 1'b0;

    always #10 clk = ~clk;

    alarm_unit dut (
        .clk_i(clk), .clr_n_i(clr_n), .tick_i(tick), .run_i(run),
        .set_mode_i(set_mode), .adj_min_i(adj_min), .adj_hr_i(adj_hr),
        .alarm_en_i(en), .cur_hr_i(cur_hr), .cur_min_i(cur_min),
        .alm_hr_o(alm_hr), .alm_min_o(alm_min), .show_alarm_o(show), .led_o(led)
    );

    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    // behavioural reference model
    always @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            m_min <= 0; m_hr <= 0; m_led <= 1'b0;
        end else begin
            if (tick && !run && set_mode && adj_min) m_min <= (m_min + 1) % 60;
            if (tick && !run && set_mode && adj_hr)  m_hr  <= (m_hr + 1) % 24;
            m_led <= run && en && (cur_hr == to_bcd(m_hr)) && (cur_min == to_bcd(m_min));
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (clr_n && !done) begin
            total++;
            if (alm_min !== to_bcd(m_min) || alm_hr !== to_bcd(m_hr) ||
                led !== m_led || show !== set_mode) begin
                bad++;
                if (alm_min !== to_bcd(m_min))
                    $display("FAIL R2 cycle minute act=%h exp=%h", alm_min, to_bcd(m_min));
                if (alm_hr !== to_bcd(m_hr))
                    $display("FAIL R4 cycle hour act=%h exp=%h", alm_hr, to_bcd(m_hr));
                if (led !== m_led)
                    $display("FAIL R5 cycle led act=%b exp=%b", led, m_led);
                if (show !== set_mode)
                    $display("FAIL R9 cycle select act=%b exp=%b", show, set_mode);
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic pulse(int n);
        repeat (n) begin
            tick = 1'b1; cyc(1);
            tick = 1'b0; cyc(1);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk("R10 reset minute", alm_min, 8'h00);
        chk("R10 reset hour", alm_hr, 8'h00);
        chk("R10 reset led", {7'd0, led}, 8'h00);
        clr_n = 1'b1;
        cyc(1);

        set_mode = 1'b1; adj_min = 1'b1;
        pulse(59);
        chk("R1 minute at max", alm_min, 8'h59);
        pulse(1);
        chk("R1 minute wrap", alm_min, 8'h00);
        chk("R4 hour untouched by minute adjust", alm_hr, 8'h00);
        pulse(30);
        chk("R2 minute stepped", alm_min, 8'h30);

        run = 1'b1;
        pulse(5);
        chk("R2 ignored while running", alm_min, 8'h30);
        run = 1'b0; set_mode = 1'b0;
        #1 chk("R9 select current", {7'd0, show}, 8'h00);
        pulse(5);
        chk("R2 ignored outside set mode", alm_min, 8'h30);
        set_mode = 1'b1;
        #1 chk("R9 select alarm", {7'd0, show}, 8'h01);
        cyc(10);
        chk("R2 no tick no step", alm_min, 8'h30);

        adj_min = 1'b0; adj_hr = 1'b1;
        pulse(23);
        chk("R3 hour at max", alm_hr, 8'h23);
        pulse(1);
        chk("R3 hour wrap", alm_hr, 8'h00);
        pulse(7);
        chk("R4 hour stepped", alm_hr, 8'h07);
        chk("R4 minute kept", alm_min, 8'h30);
        adj_hr = 1'b0; set_mode = 1'b0;

        cur_hr = 8'h07; cur_min = 8'h30; en = 1'b1;
        cyc(3);
        chk("R8 stopped clock no led", {7'd0, led}, 8'h00);
        run = 1'b1;
        cyc(1);
        chk("R5 led lit", {7'd0, led}, 8'h01);
        cyc(20);
        chk("R5 led held", {7'd0, led}, 8'h01);
        cur_min = 8'h31;
        cyc(1);
        chk("R6 led off after minute", {7'd0, led}, 8'h00);
        cur_min = 8'h30;
        cyc(1);
        chk("R5 led relit", {7'd0, led}, 8'h01);
        en = 1'b0;
        cyc(1);
        chk("R7 disable clears led", {7'd0, led}, 8'h00);
        en = 1'b1;
        cyc(1);
        cur_hr = 8'h19;
        cyc(1);
        chk("R6 hour mismatch", {7'd0, led}, 8'h00);
        cur_hr = 8'h07;
        cyc(1);
        chk("R5 led back", {7'd0, led}, 8'h01);

        #3 clr_n = 1'b0;
        #1;
        chk("R10 async minute", alm_min, 8'h00);
        chk("R10 async hour", alm_hr, 8'h00);
        chk("R10 async led", {7'd0, led}, 8'h00);
        cyc(1);
        clr_n = 1'b1;
        cur_hr = 8'h00; cur_min = 8'h00;
        cyc(2);
        chk("R5 match at midnight", {7'd0, led}, 8'h01);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule